// File: doc/BRIEF.md
# Stereo PCM Flash Playback Sequencer

This block turns a byte stream from a sequential flash reader into two channels of 8-bit DAC codes. The stored audio is a run of unsigned 8-bit samples in which left and right alternate, left first. While the play level is high and test mode is off, the block holds the reader's enable high and gives it the address of the next unplayed byte. It buffers one incoming byte and moves it into the left or right DAC register on a fixed pacing of `CLKS_PER_BYTE` clocks. With the default of 16, a stereo frame takes 32 clocks, so the system clock sets the sample rate.

Dropping the play level stops the reader and throws away the buffered byte. The block keeps the address of the next byte that has not reached a DAC, and the channel it belongs to, so playback resumes exactly where it stopped. A mirror bus repeats every new sample of one selected channel. In test mode the sequencer stops, and an input byte is written straight into the DAC chosen by the same select line.

Top module: `pcmStereoPlayer`

## Requirements
- R1: After reset, both DAC outputs and the mirror bus read 0x80, `playing` and `rdEn` are 0, and `rdAddr` is 0.
- R2: `playing` and `rdEn` are high in a cycle exactly when `playEn` was high and `testMode` was low at the preceding clock edge.
- R3: Whenever `rdEn` rises, `rdAddr` holds the address of the next byte not yet loaded into a DAC. This is 0 after reset.
- R4: The byte at an even offset from address 0 goes to the left channel (`dacOut1`), and the byte at an odd offset goes to the right channel (`dacOut0`). Exactly one DAC changes per load.
- R5: Within an uninterrupted run, consecutive DAC loads are exactly `CLKS_PER_BYTE` (16) clocks apart.
- R6: Every byte the reader delivers while enabled is played once, in address order, even when it arrives in the same cycle as a DAC load.
- R7: While `playing` is low and test mode is off, both DAC outputs and the mirror bus hold their values. After resuming, the sequence continues with no byte skipped or repeated.
- R8: On a left load the mirror bus takes the new sample when `mirrorLeft` is 1. On a right load it takes the sample when `mirrorLeft` is 0. Otherwise the mirror bus is unchanged.
- R9: After the byte at the highest address (2^`ADDR_W`-1), playback continues at address 0 on the left channel.
- R10: While `testMode` is high, `testData` is written at each clock edge into `dacOut1` if `mirrorLeft` is 1 and into `dacOut0` if it is 0. The sequencer stays idle even if `playEn` is high.
- R11: A pulse on `rdValid` while `rdEn` is low changes no output and does not enter the played sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLKS_PER_BYTE × 2 × sample rate |
| rstN | input | 1 | Asynchronous active-low reset |
| playEn | input | 1 | Play (1) or pause (0) level |
| mirrorLeft | input | 1 | Selects the mirrored channel and the test-mode target (1 = left) |
| testMode | input | 1 | Bypasses the sequencer and writes testData to a DAC |
| testData | input | 8 | Direct DAC value in test mode |
| rdData | input | 8 | Byte from the flash reader |
| rdValid | input | 1 | One-cycle strobe marking rdData valid |
| rdEn | output | 1 | Reader enable; a rising edge starts a sequential read at rdAddr |
| rdAddr | output | ADDR_W | Start address for the reader |
| dacOut0 | output | 8 | Right-channel DAC code |
| dacOut1 | output | 8 | Left-channel DAC code |
| mirrorOut | output | 8 | Copy of the selected channel's latest sample |
| playing | output | 1 | High while playback is active |

## Verification
The refill of the one-byte buffer and the DAC load that empties it can happen in the same clock. When that happens, the old byte must reach the DAC and the new byte must stay in the buffer. The bench provokes this by sweeping the gap between the reader's first and second byte from 1 to 16 clocks. A gap of 1 makes every later refill land on the load edge. Each sweep point is judged by a scoreboard that requires every DAC change to carry the next address's value, on the channel its parity selects, 16 clocks after the previous change. A pause edge that coincides with a load is covered by stepping the pause point across the frame, and is judged by the restart address the reader receives.

// File: rtl/pcmPlayerPkg.sv
package pcmPlayerPkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic bufLoad;    // capture reader byte into the holding buffer
    logic dacLoad;    // move buffered byte to its channel's DAC
    logic testWrite;  // write the direct test byte to the selected DAC
  } seqStrobes_t;

  localparam int unsigned CH_RIGHT = 0;
  localparam int unsigned CH_LEFT  = 1;

endpackage

// File: rtl/pcmSeqCtrl.sv
module pcmSeqCtrl
  import pcmPlayerPkg::*;
#(
  parameter int unsigned CLKS_PER_BYTE = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        playEn,
  input  logic        testMode,
  input  logic        rdValid,
  output logic        active,
  output seqStrobes_t strobes
);

  localparam int unsigned CNT_W = (CLKS_PER_BYTE > 2) ? $clog2(CLKS_PER_BYTE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_BYTE - 1);

  logic             bufFull;
  logic [CNT_W-1:0] paceCnt;
  logic             runReq;
  logic             seqLive;
  logic             paceDone;

  assign runReq   = playEn && !testMode;
  assign seqLive  = active && !testMode;
  assign paceDone = (paceCnt == CNT_LAST);

  assign strobes.bufLoad   = seqLive && rdValid;
  assign strobes.dacLoad   = seqLive && bufFull && paceDone;
  assign strobes.testWrite = testMode;

  // Run state: one register stage from the play level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
    end else begin
      active <= runReq;
    end
  end

  // Holding buffer occupancy; a refill on the load edge keeps it full
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFull <= 1'b0;
    end else if (!seqLive) begin
      bufFull <= 1'b0;
    end else if (strobes.bufLoad) begin
      bufFull <= 1'b1;
    end else if (strobes.dacLoad) begin
      bufFull <= 1'b0;
    end
  end

  // Pacing counter: saturates at the last count so the first byte after
  // a resume is loaded at once, later ones every CLKS_PER_BYTE clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paceCnt <= CNT_LAST;
    end else if (!active) begin
      paceCnt <= CNT_LAST;
    end else if (strobes.dacLoad) begin
      paceCnt <= '0;
    end else if (!paceDone) begin
      paceCnt <= paceCnt + 1'b1;
    end
  end

endmodule

// File: rtl/pcmSeqDatapath.sv
module pcmSeqDatapath
  import pcmPlayerPkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  seqStrobes_t                    strobes,
  input  logic                           mirrorLeft,
  input  logic [SAMPLE_W-1:0]            rdData,
  input  logic [SAMPLE_W-1:0]            testData,
  output logic [ADDR_W-1:0]              playAddr,
  output logic [1:0][SAMPLE_W-1:0]       dacCode,
  output logic [SAMPLE_W-1:0]            mirrorOut
);

  localparam logic [ADDR_W-1:0]   ADDR_LAST = {ADDR_W{1'b1}};
  localparam logic [SAMPLE_W-1:0] MID_CODE  = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] sampleBuf;
  logic                nextLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleBuf <= MID_CODE;
    end else if (strobes.bufLoad) begin
      sampleBuf <= rdData;
    end
  end

  // Position of the next unplayed byte and the channel it belongs to
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      playAddr <= '0;
      nextLeft <= 1'b1;
    end else if (strobes.dacLoad) begin
      playAddr <= playAddr + 1'b1;
      nextLeft <= (playAddr == ADDR_LAST) ? 1'b1 : !nextLeft;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mirrorOut <= MID_CODE;
    end else if (strobes.dacLoad && (nextLeft == mirrorLeft)) begin
      mirrorOut <= sampleBuf;
    end
  end

  // One DAC register per channel
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    localparam logic IS_LEFT = (ch == CH_LEFT);
    logic seqHit;
    logic testHit;

    assign seqHit  = strobes.dacLoad && (nextLeft == IS_LEFT);
    assign testHit = strobes.testWrite && (mirrorLeft == IS_LEFT);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dacCode[ch] <= MID_CODE;
      end else if (testHit) begin
        dacCode[ch] <= testData;
      end else if (seqHit) begin
        dacCode[ch] <= sampleBuf;
      end
    end
  end

endmodule

// File: rtl/pcmStereoPlayer.sv
module pcmStereoPlayer
  import pcmPlayerPkg::*;
#(
  parameter int unsigned ADDR_W        = 24,
  parameter int unsigned SAMPLE_W      = 8,
  parameter int unsigned CLKS_PER_BYTE = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                playEn,
  input  logic                mirrorLeft,
  input  logic                testMode,
  input  logic [SAMPLE_W-1:0] testData,
  input  logic [SAMPLE_W-1:0] rdData,
  input  logic                rdValid,
  output logic                rdEn,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic [SAMPLE_W-1:0] dacOut0,
  output logic [SAMPLE_W-1:0] dacOut1,
  output logic [SAMPLE_W-1:0] mirrorOut,
  output logic                playing
);

  seqStrobes_t                 strobes;
  logic                        active;
  logic [1:0][SAMPLE_W-1:0]    dacCode;

  pcmSeqCtrl #(
    .CLKS_PER_BYTE(CLKS_PER_BYTE)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .playEn   (playEn),
    .testMode (testMode),
    .rdValid  (rdValid),
    .active   (active),
    .strobes  (strobes)
  );

  pcmSeqDatapath #(
    .ADDR_W   (ADDR_W),
    .SAMPLE_W (SAMPLE_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .mirrorLeft (mirrorLeft),
    .rdData     (rdData),
    .testData   (testData),
    .playAddr   (rdAddr),
    .dacCode    (dacCode),
    .mirrorOut  (mirrorOut)
  );

  assign rdEn    = active;
  assign playing = active;
  assign dacOut0 = dacCode[CH_RIGHT];
  assign dacOut1 = dacCode[CH_LEFT];

endmodule

// File: rtl/pcmPlayerChecker.sv
module pcmPlayerChecker #(
  parameter int unsigned SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                playEn,
  input logic                mirrorLeft,
  input logic                testMode,
  input logic [SAMPLE_W-1:0] testData,
  input logic                rdEn,
  input logic [SAMPLE_W-1:0] dacOut0,
  input logic [SAMPLE_W-1:0] dacOut1,
  input logic [SAMPLE_W-1:0] mirrorOut,
  input logic                playing
);

  // R2
  play_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (playEn && !testMode) |=> (playing && rdEn));

  // R2
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(playEn && !testMode) |=> (!playing && !rdEn));

  // R7
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!playing && !testMode) |=> ($stable(dacOut0) && $stable(dacOut1) && $stable(mirrorOut)));

  // R11
  no_reader_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(mirrorOut));

  // R10
  test_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && mirrorLeft) |=> (dacOut1 == $past(testData)));

  // R10
  test_right_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && !mirrorLeft) |=> (dacOut0 == $past(testData)));

  // R8
  mirror_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(mirrorOut) && $stable(mirrorLeft))
      |-> (mirrorOut == (mirrorLeft ? dacOut1 : dacOut0)));

endmodule

bind pcmStereoPlayer pcmPlayerChecker #(
  .SAMPLE_W(SAMPLE_W)
) i_pcmPlayerChecker (
  .clk        (clk),
  .rstN       (rstN),
  .playEn     (playEn),
  .mirrorLeft (mirrorLeft),
  .testMode   (testMode),
  .testData   (testData),
  .rdEn       (rdEn),
  .dacOut0    (dacOut0),
  .dacOut1    (dacOut1),
  .mirrorOut  (mirrorOut),
  .playing    (playing)
);

// File: tb/test_pcmStereoPlayer.sv
module test_pcmStereoPlayer;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int NUM_ADDR   = 1 << ADDR_W;
  localparam int PACE       = 16;
  localparam int FIRST_LAT  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              playEn = 1'b0;
  logic              mirrorLeft = 1'b0;
  logic              testMode = 1'b0;
  logic [7:0]        testData = 8'h00;
  logic [7:0]        rdData = 8'h00;
  logic              rdValid = 1'b0;
  logic              rdEn;
  logic [ADDR_W-1:0] rdAddr;
  logic [7:0]        dacOut0, dacOut1, mirrorOut;
  logic              playing;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side scoreboard state
  int   expA = 0;
  int   cyc = 0;
  int   lastLoadCyc = 0;
  int   loads = 0;
  int   gapSel = 16;
  bit   monOn = 1'b0;
  bit   firstLoad = 1'b1;
  bit   strayReq = 1'b0;
  logic [7:0] lastL = 8'h80, lastR = 8'h80, lastM = 8'h80;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcmStereoPlayer #(.ADDR_W(ADDR_W)) i_pcmStereoPlayer (
    .clk(clk), .rstN(rstN), .playEn(playEn), .mirrorLeft(mirrorLeft),
    .testMode(testMode), .testData(testData), .rdData(rdData), .rdValid(rdValid),
    .rdEn(rdEn), .rdAddr(rdAddr), .dacOut0(dacOut0), .dacOut1(dacOut1),
    .mirrorOut(mirrorOut), .playing(playing)
  );

  function automatic logic [7:0] romByte(int a);
    return 8'((a * 17 + 3) % 256);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Flash reader model: first byte FIRST_LAT clocks after enable, second
  // after gapSel, then every PACE clocks; address wraps over ADDR_W bits
  initial begin
    bit rdOn = 1'b0;
    int rAddr = 0;
    int waitCnt = 0;
    int nIdx = 0;
    forever begin
      @(negedge clk);
      if (!rdEn) begin
        rdOn = 1'b0;
        if (strayReq) begin
          rdValid = 1'b1;          // stray strobe while idle (R11)
          rdData  = 8'hEE;
          strayReq = 1'b0;
        end else begin
          rdValid = 1'b0;
        end
      end else if (!rdOn) begin
        rdOn = 1'b1;
        rAddr = int'(rdAddr);
        check(int'(rdAddr) == expA, "R3 restart address", int'(rdAddr), expA);
        waitCnt = FIRST_LAT;
        nIdx = 0;
        rdValid = 1'b0;
      end else if (waitCnt == 0) begin
        rdValid = 1'b1;
        rdData = romByte(rAddr);
        rAddr = (rAddr + 1) % NUM_ADDR;
        waitCnt = (nIdx == 0) ? gapSel - 1 : PACE - 1;
        nIdx++;
      end else begin
        waitCnt--;
        rdValid = 1'b0;
      end
    end
  end

  // Scoreboard on DAC changes
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (monOn) begin
        bit chL, chR, isL;
        logic [7:0] val;
        chL = (dacOut1 != lastL);
        chR = (dacOut0 != lastR);
        if (chL || chR) begin
          isL = chL;
          val = chL ? dacOut1 : dacOut0;
          check(!(chL && chR), "R4 one channel per load", {chL, chR}, 1);
          check(isL == ((expA % 2) == 0), "R4 channel parity", isL, (expA % 2) == 0);
          check(val == romByte(expA), "R6 byte order", val, romByte(expA));
          if (expA == 0 && loads > 0)
            check(isL, "R9 wrap to left at address 0", isL, 1);
          if (!firstLoad)
            check(cyc - lastLoadCyc == PACE, "R5 load spacing", cyc - lastLoadCyc, PACE);
          if (isL == mirrorLeft)
            check(mirrorOut == val, "R8 mirror updated", mirrorOut, val);
          else
            check(mirrorOut == lastM, "R8 mirror unchanged", mirrorOut, lastM);
          firstLoad = 1'b0;
          lastLoadCyc = cyc;
          lastM = mirrorOut;
          expA = (expA + 1) % NUM_ADDR;
          loads++;
        end
      end
      lastL = dacOut1;
      lastR = dacOut0;
    end
  end

  task automatic runAndPause(int runLen);
    logic [7:0] holdL, holdR, holdM;
    @(negedge clk);
    playEn = 1'b1;
    firstLoad = 1'b1;
    @(negedge clk);
    check(playing && rdEn, "R2 playing after play", {playing, rdEn}, 3);
    repeat (runLen) @(negedge clk);
    playEn = 1'b0;
    @(negedge clk);
    check(!playing && !rdEn, "R2 idle after pause", {playing, rdEn}, 0);
    holdL = dacOut1; holdR = dacOut0; holdM = mirrorOut;
    strayReq = 1'b1;
    repeat (30) @(negedge clk);
    check(dacOut1 == holdL && dacOut0 == holdR, "R7 DACs hold in pause",
          {dacOut1, dacOut0}, {holdL, holdR});
    check(mirrorOut == holdM, "R11 stray strobe ignored", mirrorOut, holdM);
  endtask

  initial begin
    int gaps[4] = '{1, 3, 8, 16};
    logic [7:0] tvals[4] = '{8'h55, 8'hAA, 8'h00, 8'hFF};
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(dacOut0 == 8'h80 && dacOut1 == 8'h80, "R1 DAC reset", {dacOut1, dacOut0}, 16'h8080);
    check(mirrorOut == 8'h80, "R1 mirror reset", mirrorOut, 8'h80);
    check(!playing && !rdEn && rdAddr == '0, "R1 idle reset", {playing, rdEn, rdAddr}, 0);
    monOn = 1'b1;

    // sweep refill gap, mirror select and pause point (R5 R6 R7 R8 R9)
    for (int g = 0; g < 4; g++) begin
      for (int s = 0; s < 2; s++) begin
        gapSel = gaps[g];
        mirrorLeft = s[0];
        runAndPause(120 + 7 * (2 * g + s));
      end
    end
    check(loads > 2 * NUM_ADDR, "R9 wrap exercised", loads, 2 * NUM_ADDR);

    // test mode (R10)
    monOn = 1'b0;
    for (int v = 0; v < 4; v++) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        testMode = 1'b1;
        testData = tvals[v];
        mirrorLeft = s[0];
        @(negedge clk);
        check((s == 1 ? dacOut1 : dacOut0) == tvals[v], "R10 direct write",
              s == 1 ? dacOut1 : dacOut0, tvals[v]);
      end
    end
    playEn = 1'b1;
    repeat (3) @(negedge clk);
    check(!playing && !rdEn, "R10 sequencer idle in test mode", {playing, rdEn}, 0);
    playEn = 1'b0;
    testMode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    lastM = mirrorOut;
    monOn = 1'b1;

    // continuity after test mode (R3 R7)
    gapSel = 2;
    mirrorLeft = 1'b1;
    runAndPause(150);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule